// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This block sits between a time-quantum prescaler and the bit-level logic of a CAN controller. It counts quantum ticks to split every bit into three parts: a fixed one-quantum synchronisation slot, a programmable stretch that ends at the sample point, and a programmable stretch that runs from the sample point to the end of the bit. At the sample point it reads the receive line and produces the received bit. It can read the line once, or read it three times on consecutive quanta and keep the majority value. When three readings are selected, the stretch before the sample point grows by two quanta, so that all three readings fit ahead of the programmed point.

Falling (recessive-to-dominant) edges on the receive line move the bit grid. An edge that arrives late, before the sample point, lengthens the first stretch. An edge that arrives early, after the sample point, shortens the second stretch. Either adjustment is capped by a programmable jump width. A hard-sync request turns the next falling edge into a full restart of the bit. The unit emits a one-cycle strobe when a bit is sampled and another at the start of each bit, where a transmitter would launch its next bit.

Top module: `can_bit_timing`

## Requirements
- R1: Each bit begins with a synchronisation slot of exactly one quantum. A falling edge seen in that slot does not move the grid.
- R2: With single sampling, the sample point falls (tseg1_cfg + 1) quanta after the synchronisation slot, so `sample_stb` follows `tx_stb` by tseg1_cfg + 2 ticks.
- R3: Without resynchronisation, the next `tx_stb` follows `sample_stb` by tseg2_cfg + 1 ticks.
- R4: With single sampling, `rx_bit` takes the value of `rx_in` at the sampling tick and changes at no other time. The recessive level is 1 and the dominant level is 0.
- R5: When `triple_en` is 1, the stretch before the sample point lasts tseg1_cfg + 3 quanta.
- R6: When `triple_en` is 1, `rx_bit` is the majority of `rx_in` at the sampling tick and at the two ticks before it.
- R7: A falling edge seen on the k-th quantum after the synchronisation slot, before the sample point, delays the sample point by min(k, sjw_cfg + 1) quanta.
- R8: A falling edge seen on post-sample quantum c (counted from 0), where e = tseg2_cfg - c quanta would remain, shortens that stretch by min(e, sjw_cfg + 1). When e is not above the jump width, the new bit starts on the quantum that follows the edge.
- R9: At most one resynchronisation takes effect per bit. Later edges in the same bit are ignored.
- R10: A falling edge seen while `hard_sync_req` is 1 restarts the bit. `tx_stb` pulses for that tick, and the next sample follows it by the normal pre-sample distance.
- R11: `sample_stb` and `tx_stb` are single-cycle pulses. They are never high together and appear only after a tick. Without `tq_tick`, the timing state holds.
- R12: While `rst_n` is low, `rx_bit` is 1, and `sample_stb` and `tx_stb` are 0. The unit then starts in the synchronisation slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_tick | input | 1 | One-cycle enable marking the end of a time quantum |
| rx_in | input | 1 | Receive line, 1 = recessive |
| tseg1_cfg | input | TSEG1_W (4) | Pre-sample length minus one, in quanta |
| tseg2_cfg | input | TSEG2_W (3) | Post-sample length minus one, in quanta |
| sjw_cfg | input | SJW_W (2) | Jump width minus one |
| triple_en | input | 1 | 1 = three readings with majority vote |
| hard_sync_req | input | 1 | Turn the next falling edge into a bit restart |
| rx_bit | output | 1 | Last sampled bit value |
| sample_stb | output | 1 | Pulse: a bit was sampled this tick |
| tx_stb | output | 1 | Pulse: a new bit starts |

## Verification
The receive line is driven with bit streams whose level changes either inside the synchronisation slot, which leaves the grid alone, or at chosen quanta before or after the sample point. The bench measures tick distances between the two strobes, which separates the nominal segment lengths from extensions and shortenings, including the jump-width clip and the case where the bit ends on the edge quantum. A late rise placed on the sample quantum alone yields 1 with single sampling and 0 with the majority vote, which tells the two sampling modes apart. A second edge in an already adjusted bit, a hard-sync restart, tick pauses and a one-tick-per-cycle rate cover the remaining behaviour.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PRE  = 2'd1,
      SEG_POST = 2'd2
   } seg_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/can_bt_sampler.sv
// Receive-line history per quantum, falling-edge detection and sample vote.
module can_bt_sampler
   import can_bt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rx,
   input  logic triple,
   output logic fall_edge,
   output logic vote
);

   logic rx_q;    // line value at the previous tick
   logic rx_q2;   // line value two ticks back

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_q  <= 1'b1;
         rx_q2 <= 1'b1;
      end else if (tick) begin
         rx_q  <= rx;
         rx_q2 <= rx_q;
      end
   end

   assign fall_edge = tick & rx_q & ~rx;
   assign vote      = triple ? maj3(rx_q2, rx_q, rx) : rx;

   // R6: with three equal readings the vote can only be that level
   assert_vote_unanimous_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (triple && rx_q2 == rx && rx_q == rx) |-> vote == rx);

endmodule

// File: rtl/can_bt_seq.sv
// Segment sequencer: sync / pre-sample / post-sample with resynchronisation.
module can_bt_seq
   import can_bt_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             fall_edge,
   input  logic             hard_req,
   input  logic [CNT_W-1:0] len1,
   input  logic [CNT_W-1:0] len2,
   input  logic [CNT_W-1:0] jw,
   output logic             smp_pulse,
   output logic             tx_pulse
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   seg_e             seg, seg_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic [CNT_W-1:0] adj, adj_n;
   logic [CNT_W-1:0] err;
   logic             used, used_n;
   logic             hard, resync;

   assign hard   = tick & hard_req & fall_edge;
   assign resync = tick & fall_edge & ~used;

   always_comb begin
      seg_n     = seg;
      cnt_n     = cnt;
      adj_n     = adj;
      used_n    = used;
      err       = '0;
      smp_pulse = 1'b0;
      tx_pulse  = 1'b0;
      if (hard) begin
         seg_n    = SEG_SYNC;
         cnt_n    = '0;
         adj_n    = '0;
         used_n   = 1'b0;
         tx_pulse = 1'b1;
      end else if (tick) begin
         unique case (seg)
            SEG_SYNC: begin
               seg_n = SEG_PRE;
               cnt_n = '0;
               adj_n = '0;
            end
            SEG_PRE: begin
               if (resync) begin
                  err    = cnt + ONE;
                  adj_n  = (err < jw) ? err : jw;
                  used_n = 1'b1;
               end
               if (cnt + ONE == len1 + adj_n) begin
                  seg_n     = SEG_POST;
                  cnt_n     = '0;
                  adj_n     = '0;
                  smp_pulse = 1'b1;
               end else begin
                  cnt_n = cnt + ONE;
               end
            end
            SEG_POST: begin
               if (resync) begin
                  err    = (cnt + ONE < len2) ? (len2 - cnt - ONE) : '0;
                  adj_n  = (err < jw) ? err : jw;
                  used_n = 1'b1;
               end
               if (cnt + adj_n + ONE >= len2) begin
                  seg_n    = SEG_SYNC;
                  cnt_n    = '0;
                  adj_n    = '0;
                  used_n   = 1'b0;
                  tx_pulse = 1'b1;
               end else begin
                  cnt_n = cnt + ONE;
               end
            end
            default: seg_n = SEG_SYNC;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg  <= SEG_SYNC;
         cnt  <= '0;
         adj  <= '0;
         used <= 1'b0;
      end else begin
         seg  <= seg_n;
         cnt  <= cnt_n;
         adj  <= adj_n;
         used <= used_n;
      end
   end

   // R1: the sync slot is left after one tick unless a hard restart hits it
   assert_sync_one_quantum_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == SEG_SYNC && tick && !hard) |=> seg == SEG_PRE);

   // R11: no tick, no movement
   assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(seg) && $stable(cnt) && $stable(adj)));

   // R7: the pre-sample extension never exceeds the jump width
   assert_ext_capped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seg == SEG_PRE) |-> adj <= jw);

   // R9: once a bit has been adjusted, a further edge leaves the extension alone
   assert_single_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (used && seg == SEG_PRE && tick && fall_edge && !hard_req)
      |=> (seg != SEG_PRE || $stable(adj)));

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
   parameter int TSEG1_W        = 4,
   parameter int TSEG2_W        = 3,
   parameter int SJW_W          = 2,
   parameter bit TRIPLE_SUPPORT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tq_tick,
   input  logic               rx_in,
   input  logic [TSEG1_W-1:0] tseg1_cfg,
   input  logic [TSEG2_W-1:0] tseg2_cfg,
   input  logic [SJW_W-1:0]   sjw_cfg,
   input  logic               triple_en,
   input  logic               hard_sync_req,
   output logic               rx_bit,
   output logic               sample_stb,
   output logic               tx_stb
);

   localparam int CNT_W = ((TSEG1_W > TSEG2_W) ? TSEG1_W : TSEG2_W) + 2;
   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] C_TWO = CNT_W'(2);

   if (TSEG1_W < 1 || TSEG2_W < 1) begin : g_bad_seg_w
      $error("segment fields need at least one bit");
   end
   if (SJW_W < 1 || SJW_W > TSEG1_W) begin : g_bad_sjw_w
      $error("jump width field must be 1..TSEG1_W bits");
   end

   logic             triple_eff;
   logic [CNT_W-1:0] len1, len2, jw;
   logic             fall_edge, vote, smp_pulse, tx_pulse;

   if (TRIPLE_SUPPORT) begin : g_triple
      assign triple_eff = triple_en;
   end else begin : g_single
      assign triple_eff = 1'b0;
   end

   assign len1 = CNT_W'(tseg1_cfg) + C_ONE + (triple_eff ? C_TWO : '0);
   assign len2 = CNT_W'(tseg2_cfg) + C_ONE;
   assign jw   = CNT_W'(sjw_cfg) + C_ONE;

   can_bt_sampler u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tq_tick),
      .rx        (rx_in),
      .triple    (triple_eff),
      .fall_edge (fall_edge),
      .vote      (vote)
   );

   can_bt_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tq_tick),
      .fall_edge (fall_edge),
      .hard_req  (hard_sync_req),
      .len1      (len1),
      .len2      (len2),
      .jw        (jw),
      .smp_pulse (smp_pulse),
      .tx_pulse  (tx_pulse)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_bit     <= 1'b1;
         sample_stb <= 1'b0;
         tx_stb     <= 1'b0;
      end else begin
         sample_stb <= smp_pulse;
         tx_stb     <= tx_pulse;
         if (smp_pulse) rx_bit <= vote;
      end
   end

   // R11: the two strobes never coincide
   assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && tx_stb));

   // R11: sample strobe lasts one cycle
   assert_sample_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);

   // R4: the received bit only moves together with the sample strobe
   assert_bit_moves_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_bit) |-> sample_stb);

   // R4: single reading takes the line value at the sampling edge
   assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && !triple_eff) |-> rx_bit == $past(rx_in));

endmodule

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   typedef struct {
      logic b;
      int   pre;
      int   post;
      int   rq_val;
      int   rq_pre;
      int   rq_post;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_in = 1'b1;
   logic [3:0] tseg1_cfg = 4'd3;
   logic [2:0] tseg2_cfg = 3'd2;
   logic [1:0] sjw_cfg = 2'd1;
   logic       triple_en = 1'b0;
   logic       hard_sync_req = 1'b0;
   logic       rx_bit, sample_stb, tx_stb;
   logic       tq_tick;
   logic       phase = 1'b0;
   logic       fast_mode = 1'b0;
   logic       stall = 1'b0;
   logic       finished = 1'b0;

   int total = 0;
   int bad = 0;
   int tick_num = 0;
   int last_tx = 0;
   int last_smp = 0;
   int pend_post = 0;
   int pend_rq = 0;
   bit pend_valid = 1'b0;
   logic prev_smp = 1'b0;
   exp_t q[$];
   exp_t it;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) phase <= ~phase;
   assign tq_tick = (fast_mode | phase) & ~stall;

   always @(posedge clk) begin
      if (!rst_n) tick_num <= 0;
      else if (tq_tick) tick_num <= tick_num + 1;
   end

   can_bit_timing u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tq_tick       (tq_tick),
      .rx_in         (rx_in),
      .tseg1_cfg     (tseg1_cfg),
      .tseg2_cfg     (tseg2_cfg),
      .sjw_cfg       (sjw_cfg),
      .triple_en     (triple_en),
      .hard_sync_req (hard_sync_req),
      .rx_bit        (rx_bit),
      .sample_stb    (sample_stb),
      .tx_stb        (tx_stb)
   );

   task automatic chk(input bit ok, input int rq, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL R%0d actual=%0d expected=%0d at tick %0d", rq, act, exp, tick_num);
      end
   endtask

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   function automatic int len_pre();
      return int'(tseg1_cfg) + 1 + (triple_en ? 2 : 0);
   endfunction

   function automatic int len_post();
      return int'(tseg2_cfg) + 1;
   endfunction

   // Monitor: pops expected items as the strobes appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (sample_stb) begin
            chk(!prev_smp, 11, int'(prev_smp), 0);   // R11 single-cycle pulse
            chk(!tx_stb, 11, int'(tx_stb), 0);       // R11 strobes exclusive
            if (q.size() > 0) begin
               it = q.pop_front();
               chk(rx_bit == it.b, it.rq_val, int'(rx_bit), int'(it.b));
               chk(tick_num - last_tx == it.pre, it.rq_pre, tick_num - last_tx, it.pre);
               pend_post  = it.post;
               pend_rq    = it.rq_post;
               pend_valid = 1'b1;
            end else begin
               pend_valid = 1'b0;
            end
            last_smp = tick_num;
         end
         if (tx_stb) begin
            if (pend_valid)
               chk(tick_num - last_smp == pend_post, pend_rq, tick_num - last_smp, pend_post);
            pend_valid = 1'b0;
            last_tx = tick_num;
         end
      end
      prev_smp = sample_stb;
   end

   task automatic wait_tick(input int t);
      while (tick_num != t) @(negedge clk);
   endtask

   task automatic restart(input int t1, input int t2, input int sj, input bit tr, input bit fast);
      @(negedge clk);
      rst_n = 1'b0;
      tseg1_cfg = 4'(t1);
      tseg2_cfg = 3'(t2);
      sjw_cfg = 2'(sj);
      triple_en = tr;
      fast_mode = fast;
      rx_in = 1'b1;
      hard_sync_req = 1'b0;
      q.delete();
      pend_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R12: reset values
      chk(rx_bit == 1'b1, 12, int'(rx_bit), 1);
      chk(sample_stb == 1'b0 && tx_stb == 1'b0, 12, int'({sample_stb, tx_stb}), 0);
      rst_n = 1'b1;
   endtask

   // One bit: d = quantum after sync where the level change lands (0 = in sync slot),
   // flip = raise the line on the sample quantum only, pc = post-sample edge quantum (-1 none)
   task automatic send_bit(input logic b, input int d, input bit flip, input int pc, input int rq_pre);
      int   x, s, ext, pre, post, e;
      logic prev, val;
      bit   fall;
      exp_t ni;
      do @(negedge clk); while (!tx_stb);
      x    = tick_num;
      prev = rx_in;
      fall = prev && !b;
      ext  = (d > 0 && fall) ? imin(d, int'(sjw_cfg) + 1) : 0;
      pre  = len_pre() + 1 + ext;
      val  = flip ? !triple_en : b;
      post = len_post();
      if (pc >= 0 && ext == 0) begin
         e    = len_post() - pc - 1;
         post = len_post() - imin(e, int'(sjw_cfg) + 1);
      end
      ni.b = val; ni.pre = pre; ni.post = post;
      ni.rq_val = flip ? 6 : 4;
      ni.rq_pre = (ext > 0) ? 7 : rq_pre;
      ni.rq_post = (pc >= 0) ? ((ext > 0) ? 9 : 8) : 3;
      q.push_back(ni);
      if (d > 0) wait_tick(x + d);
      rx_in = b;
      s = x + pre;
      if (flip) begin
         wait_tick(s - 1);
         rx_in = 1'b1;
      end
      if (pc >= 0) begin
         if (rx_in == 1'b0) begin
            wait_tick(s + pc - 1);
            rx_in = 1'b1;
         end
         wait_tick(s + pc);
         rx_in = 1'b0;
      end
   endtask

   // Hard restart: falling edge on pre-sample quantum d with the request raised
   task automatic hard_bit(input int d);
      int   x;
      exp_t ni;
      do @(negedge clk); while (!tx_stb);
      x = tick_num;
      hard_sync_req = 1'b1;
      ni.b = 1'b0; ni.pre = len_pre() + 1; ni.post = len_post();
      ni.rq_val = 10; ni.rq_pre = 10; ni.rq_post = 3;
      q.push_back(ni);
      wait_tick(x + d);
      rx_in = 1'b0;
      wait_tick(x + d + 1);
      chk(tx_stb == 1'b1, 10, int'(tx_stb), 1);   // R10 restart strobe on the edge tick
      hard_sync_req = 1'b0;
   endtask

   task automatic drain();
      while (q.size() > 0 || pend_valid) @(negedge clk);
   endtask

   task automatic stall_ticks(input int n);
      @(negedge clk);
      stall = 1'b1;
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(!sample_stb && !tx_stb, 11, int'({sample_stb, tx_stb}), 0);   // R11 no strobe without ticks
      end
      stall = 1'b0;
   endtask

   initial begin
      // nominal grid, one tick per cycle, single reading (R1 R2 R3 R4)
      restart(3, 2, 1, 1'b0, 1'b1);
      send_bit(1'b1, 0, 1'b0, -1, 2);
      send_bit(1'b0, 0, 1'b0, -1, 2);
      send_bit(1'b0, 0, 1'b0, -1, 1);
      send_bit(1'b1, 0, 1'b0, -1, 2);
      send_bit(1'b0, 0, 1'b1, -1, 2);   // R4 late rise read as 1
      send_bit(1'b1, 0, 1'b0, -1, 2);
      drain();

      // slower ticks with a pause mid-bit (R11)
      restart(6, 4, 1, 1'b0, 1'b0);
      send_bit(1'b0, 0, 1'b0, -1, 2);
      stall_ticks(7);
      send_bit(1'b1, 0, 1'b0, -1, 2);
      send_bit(1'b0, 0, 1'b0, -1, 1);
      drain();

      // late edges (R7) with different jump widths
      restart(4, 3, 0, 1'b0, 1'b0);
      send_bit(1'b1, 0, 1'b0, -1, 2);
      send_bit(1'b0, 1, 1'b0, -1, 2);
      drain();
      restart(4, 3, 1, 1'b0, 1'b0);
      send_bit(1'b1, 0, 1'b0, -1, 2);
      send_bit(1'b0, 3, 1'b0, -1, 2);   // clipped to 2
      drain();
      restart(4, 3, 3, 1'b0, 1'b0);
      send_bit(1'b1, 0, 1'b0, -1, 2);
      send_bit(1'b0, 2, 1'b0, -1, 2);
      drain();

      // early edges (R8)
      restart(3, 5, 1, 1'b0, 1'b0);
      send_bit(1'b1, 0, 1'b0, 1, 2);    // shortened by 2, continues
      send_bit(1'b0, 0, 1'b0, -1, 2);
      send_bit(1'b1, 0, 1'b0, 4, 2);    // ends on the edge quantum
      send_bit(1'b0, 0, 1'b0, -1, 2);
      send_bit(1'b1, 0, 1'b0, 3, 2);
      send_bit(1'b1, 0, 1'b0, -1, 2);
      drain();

      // one adjustment per bit (R9)
      restart(4, 4, 3, 1'b0, 1'b0);
      send_bit(1'b1, 0, 1'b0, -1, 2);
      send_bit(1'b0, 2, 1'b0, 1, 2);
      send_bit(1'b1, 0, 1'b0, -1, 2);
      drain();

      // triple reading (R5 R6)
      restart(3, 2, 1, 1'b1, 1'b0);
      send_bit(1'b1, 0, 1'b0, -1, 5);
      send_bit(1'b0, 0, 1'b0, -1, 5);
      send_bit(1'b1, 0, 1'b0, -1, 5);
      send_bit(1'b0, 0, 1'b1, -1, 5);   // R6 one high reading out of three gives 0
      send_bit(1'b1, 0, 1'b0, -1, 5);
      drain();

      // hard restart (R10)
      restart(5, 2, 0, 1'b0, 1'b0);
      send_bit(1'b1, 0, 1'b0, -1, 2);
      hard_bit(3);
      send_bit(1'b1, 0, 1'b0, -1, 2);
      drain();

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule